// File: doc/BRIEF.md
# PHY Reset and Isolate-Release Sequencer

This block runs the management-side steps that bring an Ethernet PHY out of reset. It talks to the PHY through a simple register-access port: one request carries a direction, a PHY address, a register number and 16-bit write data. The far side answers with a done strobe, read data and an error flag. The serial management framing sits behind that port and is not part of this block.

After a start pulse the block reads control register 0. It clears the isolate bit (bit 10) and the autonegotiation-enable bit (bit 12), sets the reset bit (bit 15) and writes the value back. It then waits a settle interval and polls register 0 at a fixed interval until the reset bit reads back as zero, or until a bounded number of attempts has been used. On success it takes the PHY out of isolation if the polled value shows isolate still set. When SGMII mode is selected it then writes a fixed three-register setup to the same address. A one-cycle done pulse reports pass or fail. Delays are in microseconds and come from a cycle counter scaled by a ticks-per-microsecond parameter.

Top module: `phy_rst_seq`

## Requirements
- R1: After an accepted start, the first transaction is a read of register 0. If it succeeds, the next transaction writes register 0 with the value read, bit 10 and bit 12 cleared and bit 15 set.
- R2: After the reset write completes, no request is raised for at least SETTLE_US x CLK_PER_US clock cycles.
- R3: Between a failed poll read completing and the next poll read being raised, at least POLL_US x CLK_PER_US cycles pass.
- R4: Polling stops at the first read of register 0 that returns with the error flag low and bit 15 equal to 0, and no more than MAX_TRIES poll reads are issued.
- R5: A poll read returned with the error flag high counts as a used attempt, whatever its data, and polling carries on.
- R6: When MAX_TRIES poll reads pass without success, the run ends with pass low and no further write is issued.
- R7: On success, if the successful poll value has bit 10 set, that value is written back to register 0 with bit 10 cleared. Otherwise no such write occurs.
- R8: When sgmii_mode was high at start and the reset succeeded, three writes follow any isolate release, in this order: 0x8120 to register 4, 0x2801 to register 7, 0x0140 to register 0. There are no such writes on failure or with sgmii_mode low.
- R9: An error flag on the initial read of register 0 ends the run with pass low and no write.
- R10: done is high for exactly one cycle per run, and pass is high only together with done. busy is high from the cycle after an accepted start until done, and a request is raised only while busy.
- R11: A start pulse while busy is ignored. The run in progress keeps its address and produces a single done.
- R12: After reset, busy, done, pass and the request are all low.
- R13: Every transaction uses the dev_addr captured at start. Request fields stay stable from the raising of a request until its done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to begin a reset sequence |
| sgmii_mode | input | 1 | Selects the PCS setup writes after success, sampled at start |
| dev_addr | input | ADDR_W | Target device address, sampled at start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Run succeeded, valid with done |
| mgmt_req | output | 1 | Register access request, held until mgmt_done |
| mgmt_wr | output | 1 | 1 = write, 0 = read |
| mgmt_phy | output | ADDR_W | Device address of the access |
| mgmt_reg | output | REG_W | Register number of the access |
| mgmt_wdata | output | DATA_W | Write data |
| mgmt_done | input | 1 | Access complete strobe |
| mgmt_rdata | input | DATA_W | Read data, valid with mgmt_done |
| mgmt_err | input | 1 | Access failed, valid with mgmt_done |

## Verification
The bench goes after the attempt boundary. Success on the very last allowed poll must still pass, and a design with an off-by-one limit would fail there or issue an extra read. A failed read that returns all-zero data must not be taken as a cleared reset, or the run would finish early with the wrong poll count. The bench also checks that the isolate-release write appears only when the polled value carries bit 10, and that the SGMII writes never follow a failed or aborted run. The settle and poll gaps are measured at the port, which exposes a timer that is short by a microsecond or reloaded with the wrong interval.

// File: rtl/phy_rst_pkg.sv
package phy_rst_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RD_CTL,
      ST_WR_RST,
      ST_SETTLE,
      ST_POLL,
      ST_GAP,
      ST_UNISO,
      ST_CFG,
      ST_FIN
   } seq_state_e;

   // control register bit positions the sequence depends on
   localparam int CTL_BIT_RESET = 15;
   localparam int CTL_BIT_ANEN  = 12;
   localparam int CTL_BIT_ISO   = 10;

   localparam int CFG_LEN = 3;

endpackage

// File: rtl/phy_rst_ustimer.sv
module phy_rst_ustimer #(
   parameter int CLK_PER_US = 50,
   parameter int US_W       = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [US_W-1:0] us,
   output logic            expired
);
   localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
   localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CLK_PER_US - 1);

   logic             run_q;
   logic [PRE_W-1:0] pre_q;
   logic [US_W-1:0]  us_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         pre_q   <= '0;
         us_q    <= '0;
         expired <= 1'b0;
      end else begin
         expired <= 1'b0;
         if (load) begin
            run_q <= 1'b1;
            pre_q <= PRE_TOP;
            us_q  <= us - US_W'(1);
         end else if (run_q) begin
            if (pre_q == '0) begin
               pre_q <= PRE_TOP;
               if (us_q == '0) begin
                  run_q   <= 1'b0;
                  expired <= 1'b1;
               end else begin
                  us_q <= us_q - US_W'(1);
               end
            end else begin
               pre_q <= pre_q - PRE_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/phy_rst_cfgrom.sv
module phy_rst_cfgrom #(
   parameter int REG_W  = 5,
   parameter int DATA_W = 16
) (
   input  logic [1:0]        idx,
   output logic [REG_W-1:0]  reg_no,
   output logic [DATA_W-1:0] value
);
   always_comb begin
      case (idx)
         2'd0:    begin reg_no = REG_W'(4); value = DATA_W'(16'h8120); end
         2'd1:    begin reg_no = REG_W'(7); value = DATA_W'(16'h2801); end
         default: begin reg_no = REG_W'(0); value = DATA_W'(16'h0140); end
      endcase
   end
endmodule

// File: rtl/phy_rst_seq.sv
module phy_rst_seq
   import phy_rst_pkg::*;
#(
   parameter int CLK_PER_US = 50,
   parameter int SETTLE_US  = 300,
   parameter int POLL_US    = 10,
   parameter int MAX_TRIES  = 10000,
   parameter int ADDR_W     = 5,
   parameter int REG_W      = 5,
   parameter int DATA_W     = 16,
   parameter bit SGMII_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              sgmii_mode,
   input  logic [ADDR_W-1:0] dev_addr,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic              mgmt_req,
   output logic              mgmt_wr,
   output logic [ADDR_W-1:0] mgmt_phy,
   output logic [REG_W-1:0]  mgmt_reg,
   output logic [DATA_W-1:0] mgmt_wdata,
   input  logic              mgmt_done,
   input  logic [DATA_W-1:0] mgmt_rdata,
   input  logic              mgmt_err
);
   localparam int US_MAX = (SETTLE_US > POLL_US) ? SETTLE_US : POLL_US;
   localparam int US_W   = $clog2(US_MAX + 1);
   localparam int TRY_W  = $clog2(MAX_TRIES + 1);
   localparam logic [DATA_W-1:0] M_RST = DATA_W'(1) << CTL_BIT_RESET;
   localparam logic [DATA_W-1:0] M_AN  = DATA_W'(1) << CTL_BIT_ANEN;
   localparam logic [DATA_W-1:0] M_ISO = DATA_W'(1) << CTL_BIT_ISO;

   generate
      if (CLK_PER_US < 1) begin : g_bad_clk
         $error("CLK_PER_US must be at least 1");
      end
      if (SETTLE_US < 1 || POLL_US < 1) begin : g_bad_us
         $error("SETTLE_US and POLL_US must be at least 1");
      end
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("MAX_TRIES must be at least 1");
      end
      if (DATA_W < 16) begin : g_bad_data
         $error("DATA_W must hold a 16-bit register");
      end
   endgenerate

   seq_state_e        st_q, st_d;
   logic [DATA_W-1:0] ctl_q;
   logic [TRY_W-1:0]  tries_q;
   logic [1:0]        cfg_idx_q;
   logic              ok_q;
   logic [ADDR_W-1:0] addr_q;
   logic              sgmii_q;

   logic              cfg_on;
   logic [REG_W-1:0]  cfg_reg;
   logic [DATA_W-1:0] cfg_val;

   logic              tmr_load;
   logic [US_W-1:0]   tmr_us;
   logic              tmr_exp;

   logic              poll_good;
   logic              poll_last;

   generate
      if (SGMII_EN) begin : g_cfg
         phy_rst_cfgrom #(.REG_W(REG_W), .DATA_W(DATA_W)) u_rom (
            .idx    (cfg_idx_q),
            .reg_no (cfg_reg),
            .value  (cfg_val)
         );
         assign cfg_on = sgmii_q;
      end else begin : g_nocfg
         assign cfg_reg = '0;
         assign cfg_val = '0;
         assign cfg_on  = 1'b0;
      end
   endgenerate

   phy_rst_ustimer #(.CLK_PER_US(CLK_PER_US), .US_W(US_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .us      (tmr_us),
      .expired (tmr_exp)
   );

   assign poll_good = !mgmt_err && !mgmt_rdata[CTL_BIT_RESET];
   assign poll_last = (tries_q + TRY_W'(1)) == TRY_W'(MAX_TRIES);

   always_comb begin
      tmr_load = 1'b0;
      tmr_us   = US_W'(POLL_US);
      if (st_q == ST_WR_RST && mgmt_done) begin
         tmr_load = 1'b1;
         tmr_us   = US_W'(SETTLE_US);
      end else if (st_q == ST_POLL && mgmt_done && !poll_good && !poll_last) begin
         tmr_load = 1'b1;
      end
   end

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:   if (start) st_d = ST_RD_CTL;
         ST_RD_CTL: if (mgmt_done) st_d = mgmt_err ? ST_FIN : ST_WR_RST;
         ST_WR_RST: if (mgmt_done) st_d = ST_SETTLE;
         ST_SETTLE: if (tmr_exp) st_d = ST_POLL;
         ST_POLL:
            if (mgmt_done) begin
               if (poll_good)
                  st_d = mgmt_rdata[CTL_BIT_ISO] ? ST_UNISO : (cfg_on ? ST_CFG : ST_FIN);
               else
                  st_d = poll_last ? ST_FIN : ST_GAP;
            end
         ST_GAP:    if (tmr_exp) st_d = ST_POLL;
         ST_UNISO:  if (mgmt_done) st_d = cfg_on ? ST_CFG : ST_FIN;
         ST_CFG:    if (mgmt_done && cfg_idx_q == 2'(CFG_LEN - 1)) st_d = ST_FIN;
         ST_FIN:    st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         ctl_q     <= '0;
         tries_q   <= '0;
         cfg_idx_q <= '0;
         ok_q      <= 1'b0;
         addr_q    <= '0;
         sgmii_q   <= 1'b0;
      end else begin
         st_q <= st_d;
         case (st_q)
            ST_IDLE:
               if (start) begin
                  addr_q    <= dev_addr;
                  sgmii_q   <= sgmii_mode;
                  ok_q      <= 1'b0;
                  tries_q   <= '0;
                  cfg_idx_q <= '0;
               end
            ST_RD_CTL:
               if (mgmt_done) ctl_q <= (mgmt_rdata & ~(M_ISO | M_AN)) | M_RST;
            ST_POLL:
               if (mgmt_done) begin
                  tries_q <= tries_q + TRY_W'(1);
                  if (poll_good) begin
                     ctl_q <= mgmt_rdata;
                     ok_q  <= 1'b1;
                  end
               end
            ST_CFG:
               if (mgmt_done) cfg_idx_q <= cfg_idx_q + 2'd1;
            default: ;
         endcase
      end
   end

   always_comb begin
      mgmt_req   = 1'b0;
      mgmt_wr    = 1'b0;
      mgmt_reg   = '0;
      mgmt_wdata = '0;
      case (st_q)
         ST_RD_CTL, ST_POLL: mgmt_req = 1'b1;
         ST_WR_RST: begin
            mgmt_req   = 1'b1;
            mgmt_wr    = 1'b1;
            mgmt_wdata = ctl_q;
         end
         ST_UNISO: begin
            mgmt_req   = 1'b1;
            mgmt_wr    = 1'b1;
            mgmt_wdata = ctl_q & ~M_ISO;
         end
         ST_CFG: begin
            mgmt_req   = 1'b1;
            mgmt_wr    = 1'b1;
            mgmt_reg   = cfg_reg;
            mgmt_wdata = cfg_val;
         end
         default: ;
      endcase
   end

   assign mgmt_phy = addr_q;
   assign busy     = (st_q != ST_IDLE);
   assign done     = (st_q == ST_FIN);
   assign pass     = done && ok_q;

endmodule

// File: rtl/phy_rst_seq_chk.sv
module phy_rst_seq_chk #(
   parameter int SETTLE_CYC = 15000,
   parameter int MAX_TRIES  = 10000,
   parameter int ADDR_W     = 5,
   parameter int REG_W      = 5,
   parameter int DATA_W     = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              pass,
   input logic              mgmt_req,
   input logic              mgmt_wr,
   input logic [ADDR_W-1:0] mgmt_phy,
   input logic [REG_W-1:0]  mgmt_reg,
   input logic [DATA_W-1:0] mgmt_wdata,
   input logic              mgmt_done
);
   logic        req_d;
   logic        arm_q;
   logic [31:0] gap_q;
   logic [31:0] rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_d <= 1'b0;
         arm_q <= 1'b0;
         gap_q <= '0;
         rd_q  <= '0;
      end else begin
         req_d <= mgmt_req;
         gap_q <= mgmt_req ? 32'd0 : gap_q + 32'd1;
         if (mgmt_req && mgmt_done && mgmt_wr && mgmt_reg == '0 && mgmt_wdata[15])
            arm_q <= 1'b1;
         else if (mgmt_req && !req_d)
            arm_q <= 1'b0;
         if (start && !busy)
            rd_q <= '0;
         else if (mgmt_req && mgmt_done && !mgmt_wr && mgmt_reg == '0)
            rd_q <= rd_q + 32'd1;
      end
   end

   AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (mgmt_req && !req_d && arm_q) |-> gap_q >= 32'(SETTLE_CYC)); // R2
   AST_POLL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_q <= 32'(MAX_TRIES + 1)); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_PASS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      pass |-> done); // R10
   AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mgmt_req |-> busy); // R10
   AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mgmt_req && !mgmt_done) |=> (mgmt_req && $stable(mgmt_wr) && $stable(mgmt_phy)
                                    && $stable(mgmt_reg) && $stable(mgmt_wdata))); // R13

endmodule

bind phy_rst_seq phy_rst_seq_chk #(
   .SETTLE_CYC (SETTLE_US * CLK_PER_US),
   .MAX_TRIES  (MAX_TRIES),
   .ADDR_W     (ADDR_W),
   .REG_W      (REG_W),
   .DATA_W     (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .done       (done),
   .pass       (pass),
   .mgmt_req   (mgmt_req),
   .mgmt_wr    (mgmt_wr),
   .mgmt_phy   (mgmt_phy),
   .mgmt_reg   (mgmt_reg),
   .mgmt_wdata (mgmt_wdata),
   .mgmt_done  (mgmt_done)
);

// File: tb/phy_rst_seq_tb.sv
`timescale 1ns/1ps
module phy_rst_seq_tb;
   localparam int K    = 2;
   localparam int SUS  = 300;
   localparam int PUS  = 10;
   localparam int MAXT = 6;
   localparam int LAT  = 3;

   typedef struct packed {
      logic [15:0] init;
      logic [7:0]  nbusy;
      logic [15:0] post;
      logic [15:0] emask;
      logic        sg;
      logic        epass;
      logic [7:0]  epolls;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{16'h1140, 8'd2, 16'h1140, 16'h0000, 1'b0, 1'b1, 8'd3},
      '{16'h1540, 8'd0, 16'h0540, 16'h0000, 1'b0, 1'b1, 8'd1},
      '{16'h3100, 8'd6, 16'h1140, 16'h0000, 1'b0, 1'b0, 8'd6},
      '{16'h0000, 8'd5, 16'h0000, 16'h0000, 1'b0, 1'b1, 8'd6},
      '{16'h1140, 8'd1, 16'h1140, 16'h000C, 1'b0, 1'b1, 8'd4},
      '{16'h1140, 8'd0, 16'h1140, 16'h007E, 1'b0, 1'b0, 8'd6},
      '{16'h1140, 8'd1, 16'h0140, 16'h0000, 1'b1, 1'b1, 8'd2},
      '{16'h0540, 8'd0, 16'h0540, 16'h0000, 1'b1, 1'b1, 8'd1},
      '{16'h1140, 8'd6, 16'h0540, 16'h0000, 1'b1, 1'b0, 8'd6},
      '{16'h1140, 8'd0, 16'h1140, 16'h0001, 1'b1, 1'b0, 8'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        sgmii_mode = 1'b0;
   logic [4:0]  dev_addr = 5'd0;
   logic        busy, done, pass;
   logic        mgmt_req, mgmt_wr;
   logic [4:0]  mgmt_phy, mgmt_reg;
   logic [15:0] mgmt_wdata;
   logic        mgmt_done = 1'b0;
   logic [15:0] mgmt_rdata = 16'h0;
   logic        mgmt_err = 1'b0;

   always #10 clk = ~clk;

   phy_rst_seq #(
      .CLK_PER_US (K), .SETTLE_US (SUS), .POLL_US (PUS), .MAX_TRIES (MAXT),
      .ADDR_W (5), .REG_W (5), .DATA_W (16), .SGMII_EN (1'b1)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .start (start), .sgmii_mode (sgmii_mode),
      .dev_addr (dev_addr), .busy (busy), .done (done), .pass (pass),
      .mgmt_req (mgmt_req), .mgmt_wr (mgmt_wr), .mgmt_phy (mgmt_phy),
      .mgmt_reg (mgmt_reg), .mgmt_wdata (mgmt_wdata), .mgmt_done (mgmt_done),
      .mgmt_rdata (mgmt_rdata), .mgmt_err (mgmt_err)
   );

   int checks = 0;
   int errors = 0;

   // responder model state
   int          cyc = 0;
   int          cnt = 0;
   logic        c_wr;
   logic [4:0]  c_reg, c_phy;
   logic [15:0] c_dat;
   logic [15:0] m_reg0;
   int          m_busy_left, m_cfg_busy;
   logic [15:0] m_post, m_emask;
   logic [4:0]  m_addr;
   int          nrd, nwr, bad_addr;
   logic [4:0]  wl_reg [16];
   logic [15:0] wl_dat [16];
   int          t_last, last_kind, settle_gap, poll_gap;
   int          done_cnt = 0;

   always @(posedge clk) begin
      cyc       <= cyc + 1;
      mgmt_done <= 1'b0;
      mgmt_err  <= 1'b0;
      if (cnt == 0 && mgmt_req && !mgmt_done) begin
         cnt   <= LAT;
         c_wr  <= mgmt_wr;
         c_reg <= mgmt_reg;
         c_phy <= mgmt_phy;
         c_dat <= mgmt_wdata;
         if (mgmt_phy != m_addr) bad_addr <= bad_addr + 1;
         if (!mgmt_wr && last_kind == 1) settle_gap <= cyc - t_last;
         if (!mgmt_wr && last_kind == 2) poll_gap <= cyc - t_last;
      end else if (cnt == 1) begin
         cnt       <= 0;
         mgmt_done <= 1'b1;
         t_last    <= cyc;
         if (c_wr) begin
            if (nwr < 16) begin
               wl_reg[nwr] <= c_reg;
               wl_dat[nwr] <= c_dat;
            end
            nwr <= nwr + 1;
            last_kind <= (c_reg == 5'd0 && c_dat[15]) ? 1 : 0;
            if (c_reg == 5'd0) begin
               if (c_dat[15]) begin
                  m_reg0      <= m_post;
                  m_busy_left <= m_cfg_busy;
               end else begin
                  m_reg0 <= c_dat;
               end
            end
         end else begin
            nrd <= nrd + 1;
            last_kind <= (nrd > 0) ? 2 : 0;
            if (nrd < 16 && m_emask[nrd]) begin
               mgmt_err   <= 1'b1;
               mgmt_rdata <= 16'h0000;
            end else if (c_reg != 5'd0) begin
               mgmt_rdata <= 16'h0000;
            end else if (m_busy_left > 0) begin
               mgmt_rdata  <= m_post | 16'h8000;
               m_busy_left <= m_busy_left - 1;
            end else begin
               mgmt_rdata <= m_reg0;
            end
         end
      end else if (cnt > 1) begin
         cnt <= cnt - 1;
      end
   end

   always @(negedge clk) if (done) done_cnt <= done_cnt + 1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   logic [4:0]  ex_reg [16];
   logic [15:0] ex_dat [16];
   int          ex_n;

   task automatic expect_writes(input vec_t v);
      ex_n = 0;
      if (v.emask[0]) return;
      ex_reg[ex_n] = 5'd0; ex_dat[ex_n] = (v.init & ~16'h1400) | 16'h8000; ex_n++;
      if (!v.epass) return;
      if (v.post[10]) begin
         ex_reg[ex_n] = 5'd0; ex_dat[ex_n] = v.post & ~16'h0400; ex_n++;
      end
      if (v.sg) begin
         ex_reg[ex_n] = 5'd4; ex_dat[ex_n] = 16'h8120; ex_n++;
         ex_reg[ex_n] = 5'd7; ex_dat[ex_n] = 16'h2801; ex_n++;
         ex_reg[ex_n] = 5'd0; ex_dat[ex_n] = 16'h0140; ex_n++;
      end
   endtask

   task automatic load_model(input vec_t v, input logic [4:0] a);
      m_reg0 = v.init; m_busy_left = 0; m_cfg_busy = int'(v.nbusy);
      m_post = v.post; m_emask = v.emask; m_addr = a;
      nrd = 0; nwr = 0; bad_addr = 0;
      last_kind = 0; settle_gap = -1; poll_gap = -1;
   endtask

   // returns 1 if done seen; p = pass at done
   task automatic wait_done(output bit got, output bit p);
      got = 0; p = 0;
      for (int c = 0; c < 6000 && !got; c++) begin
         @(negedge clk);
         if (done) begin got = 1; p = pass; end
      end
   endtask

   task automatic run_vec(input int i);
      vec_t v;
      bit   got, p;
      int   d0;
      logic [4:0] a;
      v = VECS[i];
      a = 5'(i + 3);
      load_model(v, a);
      expect_writes(v);
      @(negedge clk);
      sgmii_mode = v.sg; dev_addr = a; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R10", "busy after start", busy, 1);
      d0 = done_cnt;
      wait_done(got, p);
      chk(got, "R10", "done seen", got, 1);
      chk(p == v.epass, "R4/R5/R6/R9", "pass result", p, v.epass);
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R10", "done one cycle", done, 0);
      chk(nrd - 1 == int'(v.epolls) || (v.emask[0] && nrd == 1), "R4/R5",
          "poll reads", nrd - 1, v.epolls);
      chk(nwr == ex_n, "R1/R6/R7/R8/R9", "write count", nwr, ex_n);
      for (int w = 0; w < ex_n && w < nwr; w++) begin
         chk(wl_reg[w] == ex_reg[w] && wl_dat[w] == ex_dat[w], "R1/R7/R8",
             $sformatf("write %0d reg/data", w), {wl_reg[w], wl_dat[w]},
             {ex_reg[w], ex_dat[w]});
      end
      chk(bad_addr == 0, "R13", "address mismatches", bad_addr, 0);
      chk(done_cnt - d0 == 1, "R10", "done pulses", done_cnt - d0, 1);
      if (!v.emask[0])
         chk(settle_gap >= SUS * K && settle_gap <= SUS * K + 4, "R2",
             "settle gap cycles", settle_gap, SUS * K);
      if (v.epolls > 1 && v.emask == 16'h0)
         chk(poll_gap >= PUS * K && poll_gap <= PUS * K + 4, "R3",
             "poll gap cycles", poll_gap, PUS * K);
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      bit got, p;
      int d0;
      load_model(VECS[0], 5'd0);
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && pass == 0 && mgmt_req == 0, "R12",
          "outputs in reset", {busy, done, pass, mgmt_req}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(busy == 0 && mgmt_req == 0, "R12", "idle after reset",
          {busy, mgmt_req}, 0);

      for (int i = 0; i < 10; i++) run_vec(i);

      // R11: second start during a run is ignored
      load_model(VECS[0], 5'd9);
      expect_writes(VECS[0]);
      @(negedge clk);
      sgmii_mode = 1'b0; dev_addr = 5'd9; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      d0 = done_cnt;
      repeat (100) @(negedge clk);
      dev_addr = 5'd20; sgmii_mode = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(got, p);
      repeat (1500) @(negedge clk);
      chk(done_cnt - d0 == 1, "R11", "done pulses with extra start", done_cnt - d0, 1);
      chk(bad_addr == 0, "R11", "address kept", bad_addr, 0);
      chk(nwr == ex_n, "R11", "write count kept", nwr, ex_n);
      chk(busy == 0, "R11", "idle after run", busy, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule